// File: doc/BRIEF.md
# Decimating Scale Factor Calculator

This block turns a pair of image dimensions per axis (source size and target size, width and height) into the parameters a two-stage image scaler needs. For each axis it first picks a coarse power-of-two pre-decimation from the truncated integer ratio of source to target. It then computes a fine fixed-point factor on what remains after that decimation. The fine factor has twelve fractional bits and is capped at a ceiling.

One shared restoring divider computes the two axes one after the other. A request is a single-cycle `start` while the block is idle. The block answers with a single-cycle `done`, and in that same cycle the registered results become valid. The results are the packed decimation codes, the packed fine factors, an error flag per axis, and a bypass indication. The bypass indication tells the surrounding pipeline that the scaler can be skipped because neither axis changes size. A scale offset word is also provided, and it is always zero.

Top module: `sfc_top`

## Requirements
- R1: For each axis, with a nonzero target size, the decimation code is 0 when floor(src/dst) < 2, 1 when it is < 4, 2 when it is < 8, and 3 otherwise. The code is the base-2 logarithm of the decimation (1, 2, 4 or 8). `dec_field[1:0]` holds the width code and `dec_field[3:2]` holds the height code.
- R2: For each axis, with a nonzero target size, the fine factor is floor(src*4096 / (dst*decimation)). `factor_word[14:0]` holds the width factor, `factor_word[30:16]` holds the height factor, and bits 15 and 31 are zero.
- R3: Any fine factor above 0x4000 is reported as exactly 0x4000.
- R4: A zero target size on an axis sets that axis's error bit (`err[0]` for width, `err[1]` for height). It also forces that axis's code to 3 and its factor to 0x4000. The other axis is unaffected.
- R5: `bypass` is 1 only when the source width equals the target width, the source height equals the target height, and neither target size is zero.
- R6: `offset_word` is zero at all times.
- R7: A `start` seen while `busy` is low is accepted, and `busy` is high in the next cycle. `done` is high for exactly one cycle per accepted request, with `busy` low in that cycle. A `start` in the `done` cycle begins a new request. A `start` while `busy` is high is ignored: it produces no extra `done` and does not change the results.
- R8: After reset, `busy`, `done`, `bypass`, `err`, `dec_field` and `factor_word` are all zero. Results hold their values until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request pulse, sampled while idle |
| src_w | input | 13 | Source width |
| src_h | input | 13 | Source height |
| dst_w | input | 13 | Target width |
| dst_h | input | 13 | Target height |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse; results valid |
| dec_field | output | 4 | Decimation codes {height, width} |
| factor_word | output | 32 | Fine factors, width in [14:0], height in [30:16] |
| offset_word | output | 32 | Scale offset, always zero |
| bypass | output | 1 | Both axes unchanged, scaler may be skipped |
| err | output | 2 | Zero target size flags {height, width} |

## Verification
Two things can land in the same cycle: the completion pulse of one request and the acceptance of the next. The bench provokes this by driving `start` with new sizes in the very cycle `done` is observed. It then judges that `busy` rises at once and that the second `done` carries the second request's values. The opposite case is also covered: a `start` raised mid-computation with different sizes must leave the first result intact and must bring no second `done`. A single request can also carry a saturated factor on one axis and a zero-target error on the other. The bench checks that each axis keeps its own outcome.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    localparam int DIM_W  = 13;
    localparam int FRAC_W = 12;
    localparam int FACT_W = FRAC_W + 3;
    localparam int DVD_W  = DIM_W + FRAC_W;
    localparam int CODE_W = 2;
    localparam int SLOT_W = 16;

    localparam logic [FACT_W-1:0] FACT_CAP   = FACT_W'(1) << (FRAC_W + 2);
    localparam logic [FACT_W-1:0] FACT_UNITY = FACT_W'(1) << FRAC_W;
    localparam logic [CODE_W-1:0] CODE_MAX   = '1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_AXIS_X = 2'd1,
        ST_AXIS_Y = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic              err;
        logic [CODE_W-1:0] code;
        logic [FACT_W-1:0] factor;
    } axis_result_t;

    // Combine a raw quotient with the axis flags into the final result.
    function automatic axis_result_t finish_axis(
        input logic [DVD_W-1:0]  quo,
        input logic [CODE_W-1:0] code,
        input logic              zero_dst
    );
        axis_result_t r;
        r.err    = zero_dst;
        r.code   = zero_dst ? CODE_MAX : code;
        if (zero_dst || (quo > DVD_W'(FACT_CAP)))
            r.factor = FACT_CAP;
        else
            r.factor = quo[FACT_W-1:0];
        return r;
    endfunction

    function automatic logic [2*SLOT_W-1:0] pack_factors(
        input axis_result_t ax,
        input axis_result_t ay
    );
        logic [SLOT_W-1:0] lo;
        logic [SLOT_W-1:0] hi;
        lo = SLOT_W'(ax.factor);
        hi = SLOT_W'(ay.factor);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/sfc_dec_select.sv
module sfc_dec_select
    import sfc_pkg::*;
#(
    parameter int W = DIM_W
) (
    input  logic [W-1:0]      num,
    input  logic [W-1:0]      den,
    output logic [CODE_W-1:0] code
);
    localparam int CW = W + 3;

    logic [CW-1:0] num_x;
    logic [CW-1:0] den2;
    logic [CW-1:0] den4;
    logic [CW-1:0] den8;

    // floor(num/den) < k  <=>  num < k*den ; a zero den falls to the top code
    always_comb begin
        num_x = CW'(num);
        den2  = CW'(den) << 1;
        den4  = CW'(den) << 2;
        den8  = CW'(den) << 3;
        if (num_x < den2)
            code = CODE_W'(0);
        else if (num_x < den4)
            code = CODE_W'(1);
        else if (num_x < den8)
            code = CODE_W'(2);
        else
            code = CODE_W'(3);
    end

endmodule

// File: rtl/sfc_restoring_div.sv
module sfc_restoring_div #(
    parameter int DVD_W = 25,
    parameter int DVS_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DVS_W-1:0] divisor,
    output logic             fin,
    output logic [DVD_W-1:0] quotient
);
    localparam int CNT_W = $clog2(DVD_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DVD_W - 1);

    logic             run_q;
    logic             fin_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DVD_W-1:0] dvd_q;
    logic [DVD_W-1:0] quo_q;
    logic [DVS_W-1:0] den_q;
    logic [DVS_W-1:0] rem_q;

    logic [DVS_W:0] trial;
    logic [DVS_W:0] diff;
    logic           fits;

    always_comb begin
        trial = {rem_q, dvd_q[DVD_W-1]};
        fits  = trial >= {1'b0, den_q};
        diff  = trial - {1'b0, den_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            fin_q <= 1'b0;
            cnt_q <= '0;
            dvd_q <= '0;
            quo_q <= '0;
            den_q <= '0;
            rem_q <= '0;
        end else begin
            fin_q <= 1'b0;
            if (go) begin
                run_q <= 1'b1;
                cnt_q <= '0;
                dvd_q <= dividend;
                den_q <= divisor;
                quo_q <= '0;
                rem_q <= '0;
            end else if (run_q) begin
                dvd_q <= dvd_q << 1;
                quo_q <= {quo_q[DVD_W-2:0], fits};
                rem_q <= fits ? diff[DVS_W-1:0] : trial[DVS_W-1:0];
                cnt_q <= cnt_q + CNT_W'(1);
                if (cnt_q == LAST) begin
                    run_q <= 1'b0;
                    fin_q <= 1'b1;
                end
            end
        end
    end

    assign fin      = fin_q;
    assign quotient = quo_q;

    // R7: completion of the shared divider is a single pulse
    a_r7_div_fin_single: assert property (@(posedge clk) disable iff (rst)
        fin_q |=> !fin_q);

    // R7: the sequencer never restarts the divider mid-division
    a_r7_div_go_idle: assert property (@(posedge clk) disable iff (rst)
        go |-> !run_q);

endmodule

// File: rtl/sfc_top.sv
module sfc_top
    import sfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DIM_W-1:0]  src_w,
    input  logic [DIM_W-1:0]  src_h,
    input  logic [DIM_W-1:0]  dst_w,
    input  logic [DIM_W-1:0]  dst_h,
    output logic              busy,
    output logic              done,
    output logic [2*CODE_W-1:0] dec_field,
    output logic [2*SLOT_W-1:0] factor_word,
    output logic [2*SLOT_W-1:0] offset_word,
    output logic              bypass,
    output logic [1:0]        err
);
    seq_state_e state_q;

    logic [DIM_W-1:0]  hold_src_y;
    logic [DIM_W-1:0]  hold_dst_y;
    logic [CODE_W-1:0] code_x_q;
    logic [CODE_W-1:0] code_y_q;
    logic              zero_x_q;
    logic              zero_y_q;
    logic              same_q;
    axis_result_t      res_x_q;
    axis_result_t      res_y_c;

    logic [DIM_W-1:0]  sel_num;
    logic [DIM_W-1:0]  sel_den;
    logic [CODE_W-1:0] sel_code;
    logic [DVD_W-1:0]  div_dividend;
    logic              div_go;
    logic              div_fin;
    logic [DVD_W-1:0]  div_quo;

    logic              done_q;
    logic              bypass_q;
    logic [1:0]        err_q;
    logic [2*CODE_W-1:0] dec_q;
    logic [2*SLOT_W-1:0] fact_q;

    always_comb begin
        if (state_q == ST_IDLE) begin
            sel_num = src_w;
            sel_den = dst_w;
        end else begin
            sel_num = hold_src_y;
            sel_den = hold_dst_y;
        end
        div_go = ((state_q == ST_IDLE) && start) ||
                 ((state_q == ST_AXIS_X) && div_fin);
        div_dividend = {sel_num, {FRAC_W{1'b0}}} >> sel_code;
        res_y_c = finish_axis(div_quo, code_y_q, zero_y_q);
    end

    sfc_dec_select #(.W(DIM_W)) dec_sel_i (
        .num  (sel_num),
        .den  (sel_den),
        .code (sel_code)
    );

    sfc_restoring_div #(.DVD_W(DVD_W), .DVS_W(DIM_W)) div_i (
        .clk      (clk),
        .rst      (rst),
        .go       (div_go),
        .dividend (div_dividend),
        .divisor  (sel_den),
        .fin      (div_fin),
        .quotient (div_quo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            hold_src_y <= '0;
            hold_dst_y <= '0;
            code_x_q   <= '0;
            code_y_q   <= '0;
            zero_x_q   <= 1'b0;
            zero_y_q   <= 1'b0;
            same_q     <= 1'b0;
            res_x_q    <= '0;
            done_q     <= 1'b0;
            bypass_q   <= 1'b0;
            err_q      <= '0;
            dec_q      <= '0;
            fact_q     <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        hold_src_y <= src_h;
                        hold_dst_y <= dst_h;
                        code_x_q   <= sel_code;
                        zero_x_q   <= (dst_w == '0);
                        same_q     <= (src_w == dst_w) && (src_h == dst_h) &&
                                      (dst_w != '0) && (dst_h != '0);
                        state_q    <= ST_AXIS_X;
                    end
                end
                ST_AXIS_X: begin
                    if (div_fin) begin
                        res_x_q  <= finish_axis(div_quo, code_x_q, zero_x_q);
                        code_y_q <= sel_code;
                        zero_y_q <= (hold_dst_y == '0);
                        state_q  <= ST_AXIS_Y;
                    end
                end
                ST_AXIS_Y: begin
                    if (div_fin) begin
                        dec_q    <= {res_y_c.code, res_x_q.code};
                        fact_q   <= pack_factors(res_x_q, res_y_c);
                        err_q    <= {res_y_c.err, res_x_q.err};
                        bypass_q <= same_q;
                        done_q   <= 1'b1;
                        state_q  <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy        = (state_q != ST_IDLE);
    assign done        = done_q;
    assign dec_field   = dec_q;
    assign factor_word = fact_q;
    assign offset_word = '0;
    assign bypass      = bypass_q;
    assign err         = err_q;

    // R7: one pulse per request, never while busy
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
    a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !busy);
    a_r7_accept: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);

    // R3: neither factor exceeds the ceiling
    a_r3_cap: assert property (@(posedge clk) disable iff (rst)
        done_q |-> ((fact_q[FACT_W-1:0] <= FACT_CAP) &&
                    (fact_q[SLOT_W+FACT_W-1:SLOT_W] <= FACT_CAP)));

    // R4: a flagged axis carries the forced code and factor
    a_r4_err_x: assert property (@(posedge clk) disable iff (rst)
        (done_q && err_q[0]) |-> ((dec_q[1:0] == CODE_MAX) &&
                                  (fact_q[FACT_W-1:0] == FACT_CAP)));
    a_r4_err_y: assert property (@(posedge clk) disable iff (rst)
        (done_q && err_q[1]) |-> ((dec_q[3:2] == CODE_MAX) &&
                                  (fact_q[SLOT_W+FACT_W-1:SLOT_W] == FACT_CAP)));

    // R5: a bypassable result is unity scaling on both axes
    a_r5_bypass_unity: assert property (@(posedge clk) disable iff (rst)
        (done_q && bypass_q) |-> ((dec_q == '0) && (err_q == '0) &&
                                  (fact_q[FACT_W-1:0] == FACT_UNITY) &&
                                  (fact_q[SLOT_W+FACT_W-1:SLOT_W] == FACT_UNITY)));

endmodule

// File: tb/sfc_top_tb_top.sv
module sfc_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [12:0] src_w = '0, src_h = '0, dst_w = '0, dst_h = '0;
    logic        busy, done, bypass;
    logic [3:0]  dec_field;
    logic [31:0] factor_word, offset_word;
    logic [1:0]  err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    sfc_top dut_i (
        .clk(clk), .rst(rst), .start(start),
        .src_w(src_w), .src_h(src_h), .dst_w(dst_w), .dst_h(dst_h),
        .busy(busy), .done(done), .dec_field(dec_field),
        .factor_word(factor_word), .offset_word(offset_word),
        .bypass(bypass), .err(err)
    );

    localparam int NV = 10;
    localparam int VEC [NV][4] = '{
        '{640, 640, 480, 480},
        '{1920, 640, 1080, 540},
        '{1000, 999, 100, 300},
        '{8191, 1, 7, 1},
        '{800, 100, 799, 100},
        '{33, 1, 32, 1},
        '{100, 0, 50, 50},
        '{0, 0, 0, 0},
        '{15, 1, 16, 1},
        '{2048, 1024, 4095, 1024}
    };

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired: actual %0d cycles expected < 150000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic void model(input int s, input int d,
                                  output int code, output int fac, output int e);
        int ratio;
        if (d == 0) begin
            e = 1; code = 3; fac = 16384;
        end else begin
            e = 0;
            ratio = s / d;
            code = (ratio < 2) ? 0 : (ratio < 4) ? 1 : (ratio < 8) ? 2 : 3;
            fac = (s * 4096) / (d * (1 << code));
            if (fac > 16384) fac = 16384;
        end
    endfunction

    task automatic apply(input int sw, input int dw, input int sh, input int dh);
        @(negedge clk);
        src_w = 13'(sw); dst_w = 13'(dw); src_h = 13'(sh); dst_h = 13'(dh);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R7 busy after accept", int'(busy), 1);
    endtask

    task automatic wait_done();
        while (done !== 1'b1) @(negedge clk);
        chk(busy == 1'b0, "R7 busy low at done", int'(busy), 0);
    endtask

    task automatic check_res(input int sw, input int dw, input int sh, input int dh);
        int cx, fx, ex, cy, fy, ey, bp;
        model(sw, dw, cx, fx, ex);
        model(sh, dh, cy, fy, ey);
        bp = (sw == dw && sh == dh && dw != 0 && dh != 0) ? 1 : 0;
        chk(int'(dec_field[1:0]) == cx, "R1 width code", int'(dec_field[1:0]), cx);
        chk(int'(dec_field[3:2]) == cy, "R1 height code", int'(dec_field[3:2]), cy);
        chk(int'(factor_word[14:0]) == fx, "R2 R3 width factor", int'(factor_word[14:0]), fx);
        chk(int'(factor_word[30:16]) == fy, "R2 R3 height factor", int'(factor_word[30:16]), fy);
        chk(factor_word[15] == 1'b0 && factor_word[31] == 1'b0, "R2 spare bits",
            int'({factor_word[31], factor_word[15]}), 0);
        chk(int'(err) == (ey * 2 + ex), "R4 error flags", int'(err), ey * 2 + ex);
        chk(int'(bypass) == bp, "R5 bypass", int'(bypass), bp);
        chk(offset_word == 32'd0, "R6 offset", int'(offset_word), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(busy == 1'b0 && done == 1'b0, "R8 reset handshake", int'({busy, done}), 0);
        chk(dec_field == '0 && factor_word == '0, "R8 reset results", int'(factor_word), 0);
        chk(bypass == 1'b0 && err == '0, "R8 reset flags", int'({bypass, err}), 0);
        chk(offset_word == 32'd0, "R6 offset in reset", int'(offset_word), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R8 idle after reset", int'({busy, done}), 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);
            wait_done();
            check_res(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);
            @(negedge clk);
            chk(done == 1'b0, "R7 done single cycle", int'(done), 1'b0);
            // R8: results hold after done
            check_res(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);
        end

        // R7: start while busy is ignored
        apply(1920, 640, 1080, 540);
        repeat (5) @(negedge clk);
        src_w = 13'd100; dst_w = 13'd0; src_h = 13'd640; dst_h = 13'd640;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check_res(1920, 640, 1080, 540);
        begin
            int extra = 0;
            for (int k = 0; k < 120; k++) begin
                @(negedge clk);
                if (done) extra = extra + 1;
            end
            chk(extra == 0, "R7 no done from ignored start", extra, 0);
        end
        check_res(1920, 640, 1080, 540);

        // R7: start in the done cycle is accepted
        apply(800, 100, 799, 100);
        wait_done();
        check_res(800, 100, 799, 100);
        src_w = 13'd33; dst_w = 13'd1; src_h = 13'd50; dst_h = 13'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1 && done == 1'b0, "R7 back-to-back accept", int'({busy, done}), 2);
        wait_done();
        // R3 on width with R4 on height in one result
        check_res(33, 1, 50, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule